// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block puts one byte into an internal configuration register of a serial-link PHY. The PHY has a small serial test port with four parts: a clear line, a strobe line, an enable line, and an 8-bit bus. The bus carries the register code and the data value at different times. A controller gives the block a register code, a data byte and a single-cycle start pulse. The block then runs a fixed sequence of eight steps on the test port and finishes with a one-cycle done pulse.

Each step holds its line levels for `STEP_CYCLES` system clock cycles before the next control change. This lets the PHY's setup and hold windows be met from a fast system clock. The PHY takes the register code on the strobe's falling edge while enable is high. It takes the data byte on the following rising edge while enable is low. The frequency-range control of a typical receiver PHY, for example, is reached with register code 0x44.

Top module: `phy_test_writer`

## Requirements
- R1: After reset, `tst_clr`, `tst_clk`, `tst_en`, `tst_bus`, `busy` and `done` are all low or zero.
- R2: A `start` seen while idle stores `code` and `data`. `busy` is high from the next cycle through the last cycle of the sequence, which is 8*`STEP_CYCLES` cycles in total. `busy` only rises after a start.
- R3: The first step drives `tst_clr` high, with `tst_clk` low, `tst_en` low and `tst_bus` at 0. The second step releases `tst_clr` and keeps the other lines unchanged.
- R4: The third step raises `tst_clk`, with `tst_en` low and `tst_bus` at 0.
- R5: The fourth step drives `tst_en` high and puts the stored code on `tst_bus`, with `tst_clk` still high. The fifth step lowers `tst_clk` and holds `tst_en` and the code.
- R6: The sixth step drives `tst_en` low and puts the stored data on `tst_bus`, with `tst_clk` low. The seventh step raises `tst_clk`. The eighth step lowers `tst_clk`. The data stays on the bus through all three steps.
- R7: `done` is high for exactly one cycle, in the cycle right after the eighth step. In that cycle `busy` is low and all test-port lines are back to zero.
- R8: A `start` that arrives while `busy` is high is ignored. The running sequence keeps its original code and data, and no second sequence follows it.
- R9: `tst_bus` and `tst_en` never change in a cycle where `tst_clk` changes. Every strobe edge therefore sees a stable bus and enable.
- R10: Each of the eight steps lasts exactly `STEP_CYCLES` cycles (`STEP_CYCLES` >= 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin one write |
| code | input | 8 | PHY register code, sampled at start |
| data | input | 8 | Value to write, sampled at start |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| tst_clr | output | 1 | Test-port clear line |
| tst_clk | output | 1 | Test-port strobe line |
| tst_en | output | 1 | Test-port enable line |
| tst_bus | output | 8 | Shared code/data bus of the test port |

## Verification
The assertions check the following on every cycle:
- the bus and enable are stable whenever the strobe moves;
- clear is only driven with every other line quiet;
- enable never rises outside a running sequence;
- `busy` never starts without a request;
- `done` is a single-cycle pulse that arrives with the port idle.

Some properties need the bench's directed scenarios, because only they can show them:
- the exact order of the eight steps and the length of each step;
- which byte sits on the bus in each step;
- that a start request issued in the middle of a write leaves the write unchanged.

// File: rtl/phy_test_writer.sv
module phy_test_writer #(
  parameter int STEP_CYCLES = 2,
  parameter int BUS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] code,
  input  logic [BUS_W-1:0] data,
  output logic             busy,
  output logic             done,
  output logic             tst_clr,
  output logic             tst_clk,
  output logic             tst_en,
  output logic [BUS_W-1:0] tst_bus
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_REL, ST_RISE, ST_CODE, ST_FALL, ST_DATA, ST_LATCH, ST_END
  } step_t;

  step_t            st;
  logic [CW-1:0]    cnt;
  logic [BUS_W-1:0] code_q, data_q;
  logic             step_over;

  assign step_over = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      code_q <= '0;
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        cnt <= '0;
        if (start) begin
          code_q <= code;
          data_q <= data;
          st     <= ST_CLR;
        end
      end else if (step_over) begin
        cnt <= '0;
        if (st == ST_END) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else begin
          st <= step_t'(st + 4'd1);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy    = (st != ST_IDLE);
  assign tst_clr = (st == ST_CLR);
  assign tst_clk = (st == ST_RISE) || (st == ST_CODE) || (st == ST_LATCH);
  assign tst_en  = (st == ST_CODE) || (st == ST_FALL);

  always_comb begin
    case (st)
      ST_CODE, ST_FALL:            tst_bus = code_q;
      ST_DATA, ST_LATCH, ST_END:   tst_bus = data_q;
      default:                     tst_bus = '0;
    endcase
  end
endmodule

// File: rtl/phy_test_writer_chk.sv
module phy_test_writer_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             tst_clr,
  input logic             tst_clk,
  input logic             tst_en,
  input logic [BUS_W-1:0] tst_bus
);
  // R9
  strobe_edge_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_clk != $past(tst_clk)) |-> ($stable(tst_bus) && $stable(tst_en)));

  // R3
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_clr |-> (!tst_clk && !tst_en && tst_bus == '0));

  // R5
  enable_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_en |-> busy);

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tst_clk && !tst_en && !tst_clr && tst_bus == '0));
endmodule

bind phy_test_writer phy_test_writer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tst_clr(tst_clr), .tst_clk(tst_clk), .tst_en(tst_en), .tst_bus(tst_bus)
);

// File: tb/test_phy_test_writer.sv
module test_phy_test_writer;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] code = '0, data = '0;
  logic       busy, done, tst_clr, tst_clk, tst_en;
  logic [7:0] tst_bus;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  phy_test_writer #(.STEP_CYCLES(STEP), .BUS_W(8)) i_phy_test_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .data(data),
    .busy(busy), .done(done), .tst_clr(tst_clr), .tst_clk(tst_clk),
    .tst_en(tst_en), .tst_bus(tst_bus)
  );

  function automatic logic [11:0] expect_vec(int ph, logic [7:0] c, logic [7:0] d);
    case (ph)
      0: return {1'b1, 1'b1, 1'b0, 1'b0, 8'h00};
      1: return {1'b1, 1'b0, 1'b0, 1'b0, 8'h00};
      2: return {1'b1, 1'b0, 1'b1, 1'b0, 8'h00};
      3: return {1'b1, 1'b0, 1'b1, 1'b1, c};
      4: return {1'b1, 1'b0, 1'b0, 1'b1, c};
      5: return {1'b1, 1'b0, 1'b0, 1'b0, d};
      6: return {1'b1, 1'b0, 1'b1, 1'b0, d};
      default: return {1'b1, 1'b0, 1'b0, 1'b0, d};
    endcase
  endfunction

  function automatic string req_of(int ph);
    if (ph < 2) return "R3";
    if (ph == 2) return "R4";
    if (ph < 5) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write; inject_at >= 0 pulses start (with other values) mid-run (R8)
  task automatic run_write(logic [7:0] c, logic [7:0] d, int inject_at);
    @(negedge clk);
    start = 1'b1; code = c; data = d;
    @(negedge clk);
    start = 1'b0; code = ~c; data = ~d;
    for (int i = 0; i < 8 * STEP; i++) begin
      // R2 R10: busy plus line levels per step, STEP cycles each
      check(req_of(i / STEP),
            {20'd0, busy, tst_clr, tst_clk, tst_en, tst_bus},
            {20'd0, expect_vec(i / STEP, c, d)});
      check("R7", {31'd0, done}, 32'd0);
      if (i == inject_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    // R7: done cycle, port idle
    check("R7", {27'd0, done, busy, tst_clr, tst_clk, tst_en}, {27'd0, 5'b10000});
    check("R7", {24'd0, tst_bus}, 32'd0);
    @(negedge clk);
    check("R7", {31'd0, done}, 32'd0);
    // R8: no second sequence after an ignored start
    check("R8", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset;
    // R1
    check("R1", {26'd0, busy, done, tst_clr, tst_clk, tst_en, 1'b0}, 32'd0);
    check("R1", {24'd0, tst_bus}, 32'd0);
  endtask

  task automatic t_idle_quiet;
    // R2: no start, nothing happens
    repeat (5) @(negedge clk);
    check("R2", {27'd0, busy, done, tst_clr, tst_clk, tst_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_quiet();
    run_write(8'h44, 8'h1A, -1);
    run_write(8'hFF, 8'h00, -1);
    run_write(8'h00, 8'hFF, -1);
    run_write(8'hA5, 8'h5A, 4);
    run_write(8'h3C, 8'hC3, 8 * STEP - 1);
    t_idle_quiet();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule